// File: doc/BRIEF.md
# Buffered-Period Remote Data Signal Timer

This block times the data-signal cycle of an infrared-remote style transmitter. A 16-bit counter runs from zero up to a programmed data length and then starts over, so one data cycle lasts data length plus one counts. A second programmed value, the active-pulse length, marks a point inside the cycle. Each of the two compare points raises its own interrupt flag. A single `tick` input advances the counter. Carrier generation, pin routing and clock division sit outside the block.

Software reaches the block through a small write port with four addresses: control, data length, active-pulse length and flag clear. Three settings shape every length write. A mode-enable bit gates all length writes. With the buffer-enable bit cleared, a length write goes straight to the active compare value. With the buffer-enable bit set, the value waits in a staging register under a busy flag and moves to the active value at the next cycle end, or at once when the counter is idle. A software reset strobe stops the counter and clears the flags. All state is brought out on a 16-bit status word, on the counter value, on the two active compare values and on an `irq` line.

Top module: `rdt_timer`

## Requirements
- R1: While running, each `tick` moves `cnt` up by one. When a tick arrives with `cnt` greater than or equal to the active data length, `cnt` returns to 0 instead. With no tick, `cnt` holds. While not running, `cnt` is 0.
- R2: Control sits at address 0: bit 0 mode enable, bit 1 buffer enable, bit 2 run, bit 3 software reset strobe (not stored), bit 4 pulse-interrupt enable, bit 5 data-interrupt enable. Status bit 10 reads 1 while the run bit is set.
- R3: A write to the data length (address 1) or to the active-pulse length (address 2) has no effect while mode enable is 0.
- R4: With buffer enable 0, an accepted length write shows on `db_len`/`ap_len` after the next clock edge, and both busy bits (status bit 9 for data length, bit 8 for pulse length) stay 0.
- R5: With buffer enable 1, an accepted length write sets that register's busy bit and leaves the active value unchanged. Further writes to that register are ignored while its busy bit is 1.
- R6: A staged value moves to the active register, and its busy bit clears on the same edge, on the tick that ends a data cycle, or on the first edge after the write when the counter is not running.
- R7: Status bit 0 (pulse flag) sets on a running tick that finds `cnt` equal to `ap_len`. Status bit 1 (data flag) sets on a running tick that finds `cnt` equal to `db_len`.
- R8: Writing address 3 clears each flag whose data bit (bit 0 pulse, bit 1 data) is 1. Zero bits leave the flags unchanged.
- R9: A control write with bit 3 set clears both flags, the run bit and `cnt` on the same edge.
- R10: `irq` is 1 exactly when some flag is 1 and its enable bit is 1.
- R11: A synchronous reset clears the counter, flags, control bits, busy bits, staging and active values. Status bits 15..11 and 7..2 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable; advances the counter while running |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 data length, 2 pulse length, 3 flag clear |
| wr_data | input | 16 | Write data |
| status | output | 16 | Run (10), data busy (9), pulse busy (8), data flag (1), pulse flag (0) |
| cnt | output | 16 | Current data-cycle count |
| db_len | output | 16 | Active data length |
| ap_len | output | 16 | Active pulse length |
| irq | output | 1 | Masked OR of the flags |

## Verification
Most internal faults show up on the ports within one data cycle. A wrong wrap comparison stretches or shortens the cycle, and `cnt` shows this on the tick after the last count. A busy bit stuck at 1 blocks the transfer, so `db_len` never changes at the cycle end. A busy bit that clears too early lets a second write through, and that value then appears on the active output. Compare flags that are off by one tick set one cycle early or late against `cnt`, so checking the status word on every cycle of a short period catches them at once.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

    localparam int DW = 16;
    localparam int AW = 2;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_DBLEN = 2'd1,
        ADDR_APLEN = 2'd2,
        ADDR_FCLR  = 2'd3
    } addr_e;

    localparam int C_MODE = 0;
    localparam int C_BUF  = 1;
    localparam int C_RUN  = 2;
    localparam int C_SRST = 3;
    localparam int C_APIE = 4;
    localparam int C_DBIE = 5;

    localparam int S_RUN   = 10;
    localparam int S_DBBSY = 9;
    localparam int S_APBSY = 8;

    // flag / length slot index: 0 = active pulse, 1 = data length
    localparam int IDX_AP = 0;
    localparam int IDX_DB = 1;
    localparam int NCMP   = 2;

    typedef struct packed {
        logic db_ie;
        logic ap_ie;
        logic run;
        logic buf_en;
        logic mode_en;
    } ctrl_t;

    function automatic logic [15:0] pack_status(input logic run,
                                                input logic [NCMP-1:0] busy,
                                                input logic [NCMP-1:0] flags);
        logic [15:0] s;
        s          = '0;
        s[S_RUN]   = run;
        s[S_DBBSY] = busy[IDX_DB];
        s[S_APBSY] = busy[IDX_AP];
        s[NCMP-1:0] = flags;
        return s;
    endfunction

endpackage

// File: rtl/rdt_ctrl.sv
module rdt_ctrl
    import rdt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [5:0]    wdata,
    output rdt_pkg::ctrl_t ctrl,
    output logic          srst
);
    assign srst = we & wdata[C_SRST];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (we) begin
            ctrl.mode_en <= wdata[C_MODE];
            ctrl.buf_en  <= wdata[C_BUF];
            ctrl.run     <= wdata[C_RUN] & ~wdata[C_SRST];
            ctrl.ap_ie   <= wdata[C_APIE];
            ctrl.db_ie   <= wdata[C_DBIE];
        end
    end
endmodule

// File: rtl/rdt_len_stage.sv
module rdt_len_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         buf_en,
    input  logic         xfer_ok,
    output logic [W-1:0] act,
    output logic         busy
);
    logic [W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            act     <= '0;
            busy    <= 1'b0;
        end else begin
            if (busy && xfer_ok) begin
                act  <= stage_q;
                busy <= 1'b0;
            end
            if (we) begin
                if (!buf_en) begin
                    act <= wdata;
                end else if (!busy) begin
                    stage_q <= wdata;
                    busy    <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rdt_cnt.sv
module rdt_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         srst,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         adv,
    output logic         cyc_end
);
    assign adv     = run & tick & ~srst;
    assign cyc_end = adv & (cnt >= period);

    always_ff @(posedge clk) begin
        if (rst || srst || !run) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cyc_end ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rdt_flags.sv
module rdt_flags #(
    parameter int W = 16,
    parameter int N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             srst,
    input  logic             adv,
    input  logic [W-1:0]     cnt,
    input  logic [N*W-1:0]   cmp,
    input  logic             clr_we,
    input  logic [N-1:0]     clr_mask,
    output logic [N-1:0]     flags
);
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = adv & (cnt == cmp[i*W +: W]);

        always_ff @(posedge clk) begin
            if (rst || srst) begin
                flags[i] <= 1'b0;
            end else if (hit[i]) begin
                flags[i] <= 1'b1;
            end else if (clr_we && clr_mask[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rdt_timer.sv
module rdt_timer
    import rdt_pkg::*;
#(
    parameter int W = rdt_pkg::DW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 wr_en,
    input  logic [rdt_pkg::AW-1:0] wr_addr,
    input  logic [W-1:0]         wr_data,
    output logic [15:0]          status,
    output logic [W-1:0]         cnt,
    output logic [W-1:0]         db_len,
    output logic [W-1:0]         ap_len,
    output logic                 irq
);
    ctrl_t            ctrl;
    logic             srst_p;
    logic             run;
    logic             buf_en;
    logic             adv;
    logic             cyc_end;
    logic [NCMP-1:0]  busy;
    logic [NCMP-1:0]  flags;
    logic [W-1:0]     act [NCMP];
    logic [NCMP*W-1:0] cmp_flat;

    assign run    = ctrl.run;
    assign buf_en = ctrl.buf_en;

    rdt_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en && (wr_addr == ADDR_CTRL)),
        .wdata (wr_data[5:0]),
        .ctrl  (ctrl),
        .srst  (srst_p)
    );

    rdt_cnt #(.W(W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .srst    (srst_p),
        .run     (run),
        .tick    (tick),
        .period  (db_len),
        .cnt     (cnt),
        .adv     (adv),
        .cyc_end (cyc_end)
    );

    for (genvar i = 0; i < NCMP; i++) begin : g_len
        localparam addr_e SLOT_ADDR = (i == IDX_DB) ? ADDR_DBLEN : ADDR_APLEN;
        rdt_len_stage #(.W(W)) u_stage (
            .clk     (clk),
            .rst     (rst),
            .we      (wr_en && (wr_addr == SLOT_ADDR) && ctrl.mode_en),
            .wdata   (wr_data),
            .buf_en  (buf_en),
            .xfer_ok (!run || cyc_end),
            .act     (act[i]),
            .busy    (busy[i])
        );
        assign cmp_flat[i*W +: W] = act[i];
    end

    assign db_len = act[IDX_DB];
    assign ap_len = act[IDX_AP];

    rdt_flags #(.W(W), .N(NCMP)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .srst     (srst_p),
        .adv      (adv),
        .cnt      (cnt),
        .cmp      (cmp_flat),
        .clr_we   (wr_en && (wr_addr == ADDR_FCLR)),
        .clr_mask (wr_data[NCMP-1:0]),
        .flags    (flags)
    );

    assign status = pack_status(run, busy, flags);
    assign irq    = (flags[IDX_DB] & ctrl.db_ie) | (flags[IDX_AP] & ctrl.ap_ie);

endmodule

// File: rtl/rdt_timer_chk.sv
module rdt_timer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         run,
    input logic         buf_en,
    input logic         srst_p,
    input logic         adv,
    input logic [15:0]  status,
    input logic [W-1:0] cnt
);
    // R9
    srst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        srst_p |=> (!status[10] && cnt == '0 && status[1:0] == 2'b00));

    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !adv && !srst_p) |=> $stable(cnt));

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

    // R5
    db_busy_buf_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[9]) |-> $past(buf_en));

    // R5
    ap_busy_buf_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[8]) |-> $past(buf_en));

    // R7
    flag_run_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(status[0]) || $rose(status[1])) |-> $past(run));

    // R11
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status == 16'h0000 && cnt == '0));
endmodule

bind rdt_timer rdt_timer_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .buf_en (buf_en),
    .srst_p (srst_p),
    .adv    (adv),
    .status (status),
    .cnt    (cnt)
);

// File: tb/rdt_timer_tb.sv
module rdt_timer_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic [15:0] status;
    logic [15:0] cnt;
    logic [15:0] db_len;
    logic [15:0] ap_len;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rdt_timer u_dut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .status(status), .cnt(cnt), .db_len(db_len),
        .ap_len(ap_len), .irq(irq)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic        we;
        logic [1:0]  a;
        logic [15:0] d;
        logic        tk;
        logic [15:0] st;
        logic [15:0] c;
        logic [15:0] db;
        logic [15:0] ap;
        logic        ir;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        {4'd2,  1'b1, 2'd0, 16'h0031, 1'b0, 16'h0000, 16'd0, 16'd0, 16'd0, 1'b0}, // R2 config
        {4'd4,  1'b1, 2'd1, 16'h0003, 1'b0, 16'h0000, 16'd0, 16'd3, 16'd0, 1'b0}, // R4 direct db
        {4'd4,  1'b1, 2'd2, 16'h0001, 1'b0, 16'h0000, 16'd0, 16'd3, 16'd1, 1'b0}, // R4 direct ap
        {4'd2,  1'b1, 2'd0, 16'h0035, 1'b0, 16'h0400, 16'd0, 16'd3, 16'd1, 1'b0}, // R2 run
        {4'd1,  1'b0, 2'd0, 16'h0000, 1'b1, 16'h0400, 16'd1, 16'd3, 16'd1, 1'b0}, // R1
        {4'd7,  1'b0, 2'd0, 16'h0000, 1'b1, 16'h0401, 16'd2, 16'd3, 16'd1, 1'b1}, // R7 ap hit
        {4'd1,  1'b0, 2'd0, 16'h0000, 1'b0, 16'h0401, 16'd2, 16'd3, 16'd1, 1'b1}, // R1 hold
        {4'd1,  1'b0, 2'd0, 16'h0000, 1'b1, 16'h0401, 16'd3, 16'd3, 16'd1, 1'b1}, // R1
        {4'd7,  1'b0, 2'd0, 16'h0000, 1'b1, 16'h0403, 16'd0, 16'd3, 16'd1, 1'b1}, // R7 db hit, R1 wrap
        {4'd8,  1'b1, 2'd3, 16'h0001, 1'b0, 16'h0402, 16'd0, 16'd3, 16'd1, 1'b1}, // R8 clear ap
        {4'd8,  1'b1, 2'd3, 16'h0000, 1'b0, 16'h0402, 16'd0, 16'd3, 16'd1, 1'b1}, // R8 zero ignored
        {4'd10, 1'b1, 2'd3, 16'h0002, 1'b0, 16'h0400, 16'd0, 16'd3, 16'd1, 1'b0}, // R10 irq drops
        {4'd2,  1'b1, 2'd0, 16'h0037, 1'b0, 16'h0400, 16'd0, 16'd3, 16'd1, 1'b0}, // R2 buffer on
        {4'd5,  1'b1, 2'd1, 16'h0005, 1'b0, 16'h0600, 16'd0, 16'd3, 16'd1, 1'b0}, // R5 staged
        {4'd5,  1'b1, 2'd1, 16'h0007, 1'b0, 16'h0600, 16'd0, 16'd3, 16'd1, 1'b0}, // R5 locked out
        {4'd6,  1'b0, 2'd0, 16'h0000, 1'b1, 16'h0600, 16'd1, 16'd3, 16'd1, 1'b0}, // R6 waits
        {4'd7,  1'b0, 2'd0, 16'h0000, 1'b1, 16'h0601, 16'd2, 16'd3, 16'd1, 1'b1}, // R7
        {4'd6,  1'b0, 2'd0, 16'h0000, 1'b1, 16'h0601, 16'd3, 16'd3, 16'd1, 1'b1}, // R6
        {4'd6,  1'b0, 2'd0, 16'h0000, 1'b1, 16'h0403, 16'd0, 16'd5, 16'd1, 1'b1}, // R6 transfer at end
        {4'd9,  1'b1, 2'd0, 16'h003B, 1'b0, 16'h0000, 16'd0, 16'd5, 16'd1, 1'b0}, // R9 soft reset
        {4'd2,  1'b1, 2'd0, 16'h0030, 1'b0, 16'h0000, 16'd0, 16'd5, 16'd1, 1'b0}, // R2 mode off
        {4'd3,  1'b1, 2'd2, 16'h0009, 1'b0, 16'h0000, 16'd0, 16'd5, 16'd1, 1'b0}, // R3 ignored
        {4'd2,  1'b1, 2'd0, 16'h0033, 1'b0, 16'h0000, 16'd0, 16'd5, 16'd1, 1'b0}, // R2 mode+buf
        {4'd5,  1'b1, 2'd2, 16'h0009, 1'b0, 16'h0100, 16'd0, 16'd5, 16'd1, 1'b0}, // R5 ap busy
        {4'd6,  1'b0, 2'd0, 16'h0000, 1'b0, 16'h0000, 16'd0, 16'd5, 16'd9, 1'b0}  // R6 idle transfer
    };

    task automatic chk(input string rq, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_all(input string rq, input logic [15:0] st, input logic [15:0] c,
                             input logic [15:0] db, input logic [15:0] ap, input logic ir);
        chk(rq, "status", status, st);
        chk(rq, "cnt", cnt, c);
        chk(rq, "db_len", db_len, db);
        chk(rq, "ap_len", ap_len, ap);
        chk(rq, "irq", {15'd0, irq}, {15'd0, ir});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check_all("R11", 16'h0000, 16'd0, 16'd0, 16'd0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            wr_en = VEC[i].we; wr_addr = VEC[i].a; wr_data = VEC[i].d; tick = VEC[i].tk;
            @(negedge clk);
            wr_en = 1'b0; tick = 1'b0;
            check_all($sformatf("R%0d row %0d", VEC[i].rq, i),
                      VEC[i].st, VEC[i].c, VEC[i].db, VEC[i].ap, VEC[i].ir);
        end

        // R1 zero length: every tick ends a cycle; R10 masked flags give no irq
        wr(2'd0, 16'h0001);
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'h0000);
        check_all("R4", 16'h0000, 16'd0, 16'd0, 16'd0, 1'b0);
        wr(2'd0, 16'h0005);
        tick = 1'b1;
        @(negedge clk);
        check_all("R1", 16'h0403, 16'd0, 16'd0, 16'd0, 1'b0);
        @(negedge clk);
        tick = 1'b0;
        check_all("R1", 16'h0403, 16'd0, 16'd0, 16'd0, 1'b0);
        wr(2'd0, 16'h0025);
        check_all("R10", 16'h0403, 16'd0, 16'd0, 16'd0, 1'b1);

        // R11 hardware reset mid-run with staged value pending
        wr(2'd0, 16'h0027);
        wr(2'd1, 16'h0044);
        chk("R5", "status", status, 16'h0603);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R11", 16'h0000, 16'd0, 16'd0, 16'd0, 1'b0);

        finish_run();
    end

endmodule